// File: doc/BRIEF.md
# Vector Branch Length Truncation Unit

This block resolves a vector conditional branch by examining per-element condition outcomes one at a time, in ascending element order. It folds those outcomes into a single branch-taken decision, using either AND or OR. In the clipping modes it also finds the first element whose outcome matches a selectable polarity, and from that element it derives a shortened vector length (VL).

A 24-bit mode field selects the operating mode and the flags. A start pulse captures this field together with the current VL and the maximum vector length (MVL). Condition bits then arrive on a valid-qualified input, at most one per cycle. When evaluation ends, the block raises done for one cycle. In that cycle it presents the decision and the resulting VL, and it asserts a write strobe if VL was shortened. In the stepping modes it also emits a per-element step request, plus a flag asking that the tested condition field be rewritten. The block does not advance step counters itself, and it does not touch the link register.

Top module: `vbt_branch_vl`

## Requirements
- R1: Operating mode = {mode_i[19], mode_i[20]}. The encodings are 00 plain, 01 clip, 10 step, and 11 step with clip.
- R2: The flags sit at fixed bit positions. mode_i[4] selects AND folding (set) or OR folding (clear). mode_i[6] is the condition-rewrite flag. mode_i[7] is the clip polarity. mode_i[21] is the clip include flag. All other bits have no effect on any output.
- R3: taken_o, shown in the done cycle, is the AND of the evaluated element outcomes when mode_i[4] is set, and their OR when it is clear.
- R4: In the plain and step modes, evaluation stops at the first element that fixes the result (a 0 under AND, a 1 under OR), or at element VL-1. done_o rises in the cycle after the last accepted element.
- R5: In the clip modes, evaluation stops at the first element whose outcome equals mode_i[7], or at element VL-1. mode_i[7]=1 triggers on a passing outcome (1), and mode_i[7]=0 triggers on a failing outcome (0).
- R6: When a trigger is found at index k, vl_o = k if mode_i[21] is clear and vl_o = k+1 if it is set, and vl_we_o pulses together with done_o.
- R7: If no trigger is found, or the mode is plain or step, vl_o equals the captured VL and vl_we_o stays low.
- R8: mvl_o holds the MVL captured at the accepted start and never changes until the next accepted start.
- R9: A start accepted with vl_i = 0 raises done_o in that same cycle, with taken_o and vl_we_o low, and the block does not become busy.
- R10: Condition bits are consumed only on cycles where busy_o and cond_valid_i are both high. start_i is ignored while busy_o is high.
- R11: In the step modes, step_req_o is high on exactly each cycle an element is consumed. In the other modes it stays low.
- R12: cond_wb_o is high with step_req_o when mode_i[6] is set, and low otherwise.
- R13: After reset, busy_o, done_o, taken_o, vl_we_o, step_req_o and cond_wb_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin evaluation (accepted when not busy) |
| mode_i | input | 24 | Mode and flag field |
| vl_i | input | VL_W | Current vector length |
| mvl_i | input | VL_W | Maximum vector length |
| cond_valid_i | input | 1 | Condition bit valid |
| cond_i | input | 1 | Outcome of the current element (1 = pass) |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | Result valid this cycle |
| taken_o | output | 1 | Branch decision |
| vl_o | output | VL_W | Resulting vector length |
| vl_we_o | output | 1 | VL write strobe |
| mvl_o | output | VL_W | Captured maximum vector length |
| step_req_o | output | 1 | Step request for the element consumed |
| cond_wb_o | output | 1 | Rewrite tested condition field |

## Verification
The vector table crosses both folding kinds with both clip polarities and both include settings. Its condition patterns place the deciding element first, in the middle, at the last index, or nowhere at all. These cases separate a fold stopping early from one running to the end, a trigger on pass from one on fail, and an inclusive length from an exclusive one. A valid gap in every run shows that idle cycles consume nothing. Directed cases cover a zero length, starts raised while busy, and MVL changing after capture.

// File: rtl/vbt_pkg.sv
package vbt_pkg;
  localparam int MODE_W = 24;
  localparam int B_ALL  = 4;
  localparam int B_WB   = 6;
  localparam int B_POL  = 7;
  localparam int B_SEL0 = 19;
  localparam int B_SEL1 = 20;
  localparam int B_INCL = 21;

  typedef enum logic [1:0] {
    OP_PLAIN     = 2'b00,
    OP_CLIP      = 2'b01,
    OP_STEP      = 2'b10,
    OP_STEP_CLIP = 2'b11
  } op_e;

  typedef struct packed {
    op_e  op;
    logic all_mode;
    logic cond_wb;
    logic clip_on_pass;
    logic clip_incl;
    logic is_clip;
    logic is_step;
  } ctl_t;
endpackage

// File: rtl/vbt_decode.sv
module vbt_decode
  import vbt_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output ctl_t              ctl_o
);
  logic unused_bits;
  assign unused_bits = ^{mode_i[23:22], mode_i[18:8], mode_i[5], mode_i[3:0]};

  always_comb begin
    ctl_o.op           = op_e'({mode_i[B_SEL0], mode_i[B_SEL1]});
    ctl_o.all_mode     = mode_i[B_ALL];
    ctl_o.is_step      = mode_i[B_SEL0];
    ctl_o.is_clip      = mode_i[B_SEL1];
    ctl_o.cond_wb      = mode_i[B_WB] & mode_i[B_SEL0];
    ctl_o.clip_on_pass = mode_i[B_POL];
    ctl_o.clip_incl    = mode_i[B_INCL];
  end
endmodule

// File: rtl/vbt_fold.sv
module vbt_fold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic all_init_i,
  input  logic all_mode_i,
  input  logic en_i,
  input  logic cond_i,
  output logic decided_o,
  output logic acc_o
);
  logic acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= 1'b0;
    else if (init_i) acc_q <= all_init_i;
    else if (en_i)   acc_q <= all_mode_i ? (acc_q & cond_i) : (acc_q | cond_i);
  end

  // element that pins the fold result
  assign decided_o = en_i & (all_mode_i ? ~cond_i : cond_i);
  assign acc_o     = acc_q;

  // R3
  and_zero_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !init_i && all_mode_i && !cond_i) |=> !acc_q);
endmodule

// File: rtl/vbt_clip.sv
module vbt_clip #(
  parameter int VL_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            init_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic            on_pass_i,
  input  logic            incl_i,
  input  logic            en_i,
  input  logic [VL_W-1:0] idx_i,
  input  logic            cond_i,
  output logic            hit_o,
  output logic [VL_W-1:0] vl_o,
  output logic            we_o
);
  logic [VL_W-1:0] vl_q;
  logic            we_q;

  assign hit_o = (cond_i == on_pass_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q <= '0;
      we_q <= 1'b0;
    end else if (init_i) begin
      vl_q <= vl_i;
      we_q <= 1'b0;
    end else if (en_i && hit_o) begin
      vl_q <= incl_i ? idx_i + 1'b1 : idx_i;
      we_q <= 1'b1;
    end
  end

  assign vl_o = vl_q;
  assign we_o = we_q;
endmodule

// File: rtl/vbt_branch_vl.sv
module vbt_branch_vl
  import vbt_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [VL_W-1:0]     vl_i,
  input  logic [VL_W-1:0]     mvl_i,
  input  logic                cond_valid_i,
  input  logic                cond_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                taken_o,
  output logic [VL_W-1:0]     vl_o,
  output logic                vl_we_o,
  output logic [VL_W-1:0]     mvl_o,
  output logic                step_req_o,
  output logic                cond_wb_o
);
  ctl_t            ctl_d, ctl_q;
  logic            busy_q, fin_q;
  logic [VL_W-1:0] idx_q, vl_cap_q, mvl_q;
  logic            acc_start, zero_start, elem_en, last_elem, stop;
  logic            fold_decided, fold_acc, clip_hit, clip_we;
  logic [VL_W-1:0] clip_vl;

  vbt_decode u_decode (.mode_i(mode_i), .ctl_o(ctl_d));

  assign acc_start  = start_i & ~busy_q;
  assign zero_start = acc_start & (vl_i == '0);
  assign elem_en    = busy_q & cond_valid_i;
  assign last_elem  = (idx_q == vl_cap_q - 1'b1);
  assign stop       = elem_en & (last_elem | (ctl_q.is_clip ? clip_hit : fold_decided));

  vbt_fold u_fold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (acc_start),
    .all_init_i (ctl_d.all_mode),
    .all_mode_i (ctl_q.all_mode),
    .en_i       (elem_en),
    .cond_i     (cond_i),
    .decided_o  (fold_decided),
    .acc_o      (fold_acc)
  );

  vbt_clip #(.VL_W(VL_W)) u_clip (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (acc_start),
    .vl_i      (vl_i),
    .on_pass_i (ctl_q.clip_on_pass),
    .incl_i    (ctl_q.clip_incl),
    .en_i      (elem_en & ctl_q.is_clip),
    .idx_i     (idx_q),
    .cond_i    (cond_i),
    .hit_o     (clip_hit),
    .vl_o      (clip_vl),
    .we_o      (clip_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      fin_q    <= 1'b0;
      idx_q    <= '0;
      vl_cap_q <= '0;
      mvl_q    <= '0;
      ctl_q    <= '0;
    end else begin
      fin_q <= stop;
      if (acc_start) begin
        mvl_q <= mvl_i;
        if (!zero_start) begin
          busy_q   <= 1'b1;
          ctl_q    <= ctl_d;
          vl_cap_q <= vl_i;
          idx_q    <= '0;
        end
      end else if (elem_en) begin
        idx_q <= idx_q + 1'b1;
        if (stop) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = fin_q | zero_start;
  assign taken_o    = fin_q & fold_acc;
  assign vl_o       = zero_start ? vl_i : clip_vl;
  assign vl_we_o    = fin_q & clip_we;
  assign mvl_o      = mvl_q;
  assign step_req_o = elem_en & ctl_q.is_step;
  assign cond_wb_o  = step_req_o & ctl_q.cond_wb;

  // R4
  done_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> done_o);
  // R9
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R6
  vl_never_grows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_we_o |-> (vl_o <= vl_cap_q));
  // R7
  no_write_unclipped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_q && !ctl_q.is_clip) |-> !vl_we_o);
  // R8
  mvl_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(mvl_o));
  // R10
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(vl_cap_q));
endmodule

// File: tb/vbt_branch_vl_tb.sv
module vbt_branch_vl_tb;
  localparam int VL_W = 7;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [23:0]     mode_i = '0;
  logic [VL_W-1:0] vl_i = '0;
  logic [VL_W-1:0] mvl_i = '0;
  logic            cond_valid_i = 1'b0;
  logic            cond_i = 1'b0;
  logic            busy_o, done_o, taken_o, vl_we_o, step_req_o, cond_wb_o;
  logic [VL_W-1:0] vl_o, mvl_o;

  always #5 clk = ~clk;

  vbt_branch_vl #(.VL_W(VL_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .vl_i(vl_i), .mvl_i(mvl_i), .cond_valid_i(cond_valid_i), .cond_i(cond_i),
    .busy_o(busy_o), .done_o(done_o), .taken_o(taken_o), .vl_o(vl_o),
    .vl_we_o(vl_we_o), .mvl_o(mvl_o), .step_req_o(step_req_o), .cond_wb_o(cond_wb_o)
  );

  typedef struct packed {
    logic [1:0] op;
    logic       all_m;
    logic       pol;
    logic       incl;
    logic       wb;
    logic [3:0] vl;
    logic [7:0] cond;
    logic       e_taken;
    logic [3:0] e_vl;
    logic       e_we;
    logic [3:0] e_n;
  } vec_t;

  // op: {bit19,bit20}; cond bit i = outcome of element i
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 8'b0000_0100, 1'b1, 4'd5, 1'b0, 4'd3},
    '{2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4, 8'b0000_1111, 1'b1, 4'd4, 1'b0, 4'd4},
    '{2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6, 8'b0011_1011, 1'b0, 4'd6, 1'b0, 4'd3},
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 8'b0000_0000, 1'b0, 4'd3, 1'b0, 4'd3},
    '{2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8, 8'b0001_0000, 1'b1, 4'd4, 1'b1, 4'd5},
    '{2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6, 8'b0000_0111, 1'b0, 4'd4, 1'b1, 4'd4},
    '{2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 4'd5, 8'b0000_0000, 1'b0, 4'd5, 1'b0, 4'd5},
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 8'b1111_1110, 1'b0, 4'd0, 1'b1, 4'd1},
    '{2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 4'd7, 8'b0100_0000, 1'b1, 4'd7, 1'b1, 4'd7},
    '{2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 8'b0000_0101, 1'b0, 4'd3, 1'b0, 4'd2},
    '{2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4, 8'b0000_0001, 1'b1, 4'd0, 1'b1, 4'd1},
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4, 8'b0000_1000, 1'b1, 4'd4, 1'b0, 4'd4}
  };

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ended  = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      finish_run();
    end
  end

  function automatic logic [23:0] mk_mode(input vec_t v);
    logic [23:0] m;
    m = 24'h0;
    m[4]  = v.all_m;
    m[6]  = v.wb;
    m[7]  = v.pol;
    m[19] = v.op[1];
    m[20] = v.op[0];
    m[21] = v.incl;
    return m;
  endfunction

  // intf: pulse start again (vl=2, other mode) during the run
  task automatic run_vec(input vec_t v, input logic [23:0] mode, input bit intf, input string tag);
    int  n = 0;
    int  steps = 0;
    int  wbs = 0;
    int  guard = 0;
    bit  gap = 1'b0;
    bit  seen = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    mode_i  = mode;
    vl_i    = VL_W'(v.vl);
    mvl_i   = 7'd12;
    @(posedge clk);
    #1;
    start_i = 1'b0;
    mvl_i   = 7'd3;
    while (guard < 40) begin
      @(negedge clk);
      guard++;
      if (done_o) begin
        seen = 1'b1;
        break;
      end
      if (intf) begin
        start_i = 1'b1;
        mode_i  = 24'h0;
        vl_i    = 7'd2;
      end
      if (n == 2 && !gap) begin
        cond_valid_i = 1'b0;
        gap = 1'b1;
      end else begin
        cond_valid_i = 1'b1;
        cond_i = (n < 8) ? v.cond[n] : 1'b0;
        n++;
      end
      #1;
      if (step_req_o) steps++;
      if (cond_wb_o)  wbs++;
    end
    start_i = 1'b0;
    check(seen, {"R4 done ", tag}, int'(seen), 1);
    check(taken_o == v.e_taken, {"R3 taken ", tag}, int'(taken_o), int'(v.e_taken));
    check(int'(vl_o) == int'(v.e_vl), {"R6 vl ", tag}, int'(vl_o), int'(v.e_vl));
    check(vl_we_o == v.e_we, {"R7 vl_we ", tag}, int'(vl_we_o), int'(v.e_we));
    check(n == int'(v.e_n), {"R5 consumed ", tag}, n, int'(v.e_n));
    check(int'(mvl_o) == 12, {"R8 mvl ", tag}, int'(mvl_o), 12);
    check(steps == (v.op[1] ? n : 0), {"R11 steps ", tag}, steps, v.op[1] ? n : 0);
    check(wbs == ((v.op[1] && v.wb) ? n : 0), {"R12 wb ", tag}, wbs, (v.op[1] && v.wb) ? n : 0);
    cond_valid_i = 1'b0;
    @(negedge clk);
    check(!done_o && !busy_o, {"R10 idle ", tag}, int'(done_o), 0);
  endtask

  initial begin
    vec_t v;
    logic [23:0] m;
    // R13 reset state
    #2;
    check(!busy_o && !done_o && !taken_o && !vl_we_o && !step_req_o && !cond_wb_o,
          "R13 reset", int'({busy_o, done_o, taken_o, vl_we_o, step_req_o, cond_wb_o}), 0);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 R5 R6: table walk
    for (int k = 0; k < NV; k++) begin
      run_vec(VEC[k], mk_mode(VEC[k]), 1'b0, $sformatf("vec%0d", k));
    end

    // R2: unrelated bits set must not change vec4 result
    m = mk_mode(VEC[4]) | 24'hC0_FF2F & ~24'h3800D0;
    run_vec(VEC[4], m, 1'b0, "R2 stray bits");

    // R10: starts while busy are ignored
    v = VEC[1];
    run_vec(v, mk_mode(v), 1'b1, "R10 busy start");

    // R9: zero length completes in the accept cycle
    @(negedge clk);
    start_i = 1'b1;
    mode_i  = mk_mode(VEC[4]);
    vl_i    = '0;
    mvl_i   = 7'd9;
    #1;
    check(done_o, "R9 zero done", int'(done_o), 1);
    check(!taken_o && !vl_we_o, "R9 zero no taken/write", int'({taken_o, vl_we_o}), 0);
    @(posedge clk);
    #1 start_i = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o, "R9 zero not busy", int'({busy_o, done_o}), 0);
    check(int'(mvl_o) == 9, "R8 mvl zero", int'(mvl_o), 9);

    finish_run();
  end
endmodule